// File: doc/BRIEF.md
# Square-Wave Interval Timer Channel

This block is a single counter channel of an interval timer. It runs from a slow base tick and produces a square wave whose period is a programmed 16-bit divisor times the tick period. A typical base tick is about 1.193182 MHz. The wave serves as a periodic interrupt request line, for example the system timer interrupt on line 0. Software programs the block through two byte-wide write ports. A control-word write picks the byte access order and arms the channel. Writes to the data port then deliver the divisor.

The control word has a fixed layout: bit 0 selects BCD counting, bits 3:1 hold the operating mode, bits 5:4 hold the access mode and bits 7:6 select the channel. Only binary square-wave operation on the channel's own number is accepted. The usual setup byte 0x36 selects channel 0, low-then-high access, the square-wave mode and binary counting. A divisor change written while the wave is running waits for the next half-period boundary before it takes effect, so no half-period is ever cut short.

Top module: `tmr_channel`

## Requirements
- R1: After reset `irq_out` is 0 and stays 0 while ticks arrive. Data-port writes made before any accepted control word are ignored.
- R2: A control word is accepted only when all of the following hold: bits 7:6 equal `CHAN_ID`, bits 5:4 are non-zero, bits 2:1 are 2'b11 (mode 3 or mode 7), and bit 0 is 0. Any other control word has no effect on the running wave.
- R3: In the cycle after an accepted control word, `irq_out` is 1. Counting stays stopped until the divisor is complete, so `irq_out` holds at 1.
- R4: The access mode comes from bits 5:4. When bits 5:4 are 2'b11, the first data byte is the low byte and the second is the high byte. Counting starts one cycle after the second byte.
- R5: When bits 5:4 are 2'b01, a single data byte sets the low byte and the high byte is zero. When bits 5:4 are 2'b10, a single data byte sets the high byte and the low byte is zero.
- R6: For a divisor N, `irq_out` is high for ceil(N/2) ticks and low for floor(N/2) ticks. An odd divisor therefore gives a high half one tick longer than the low half.
- R7: A divisor of 0 is treated as 65536, giving 32768 ticks high and 32768 ticks low.
- R8: A divisor written while the channel is running takes effect at the next half-period boundary. The current half-period finishes with the old length.
- R9: The count advances only in cycles where `tick_en` is 1. Without ticks, `irq_out` does not change.
- R10: A divisor of 1 gives one tick high and one tick low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Base tick strobe, one cycle wide |
| ctl_we | input | 1 | Control-word write strobe |
| data_we | input | 1 | Data-port write strobe |
| wdata | input | 8 | Write byte shared by both ports |
| irq_out | output | 1 | Square-wave output, used as the interrupt request |

## Verification
The assertions assume the following about the inputs: `tick_en` is a single-cycle synchronous strobe, and `ctl_we` and `data_we` are never high in the same cycle. When both are high, the control word wins and the data byte is lost. The stimulus drives every input at the falling clock edge and issues at most one write per cycle. The tick generator runs at fixed spacings, or is stopped outright to exercise the no-tick case. Half-period lengths are measured in clock cycles and compared against ceil/floor of the divisor times the tick spacing.

// File: rtl/tmr_pkg.sv
// Package: shared types for the interval timer channel.
// Assumes an 8-bit write bus and a divisor of two bytes.
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam int DIV_W  = 2 * BYTE_W;

    // Byte access order selected by the control word
    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_BOTH = 2'b11
    } acc_e;

    // Control-word layout; the field positions are decoded by software
    typedef struct packed {
        logic [1:0] chan;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctlw_t;
endpackage

// File: rtl/tmr_ctl_decode.sv
// Module: tmr_ctl_decode
// Decodes a control-word write and decides whether this channel accepts it.
// Assumes: only binary square-wave operation (mode field x11) is supported;
// every other control word is dropped without side effects.
module tmr_ctl_decode
    import tmr_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic              accept,
    output acc_e              acc_mode
);
    ctlw_t word;

    // Overlay the field layout on the write byte
    assign word = ctlw_t'(wdata);

    // Accept only a matching channel, a real access mode, mode 3/7 and binary
    always_comb begin
        accept   = ctl_we
                 && (word.chan == 2'(CHAN_ID))
                 && (word.acc != ACC_NONE)
                 && (word.mode[1:0] == 2'b11)
                 && !word.bcd;
        acc_mode = word.acc;
    end
endmodule

// File: rtl/tmr_load_seq.sv
// Module: tmr_load_seq
// Assembles the divisor from data-port bytes in the order the control word chose.
// Assumes: cfg_load takes priority over a data write in the same cycle;
// before any accepted control word, data writes are ignored.
module tmr_load_seq
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  acc_e              cfg_acc,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [DIV_W-1:0]  div_q,
    output logic              div_new
);
    acc_e              acc_q;
    logic              hi_next;
    logic [BYTE_W-1:0] lo_hold;

    // Track access mode and byte pointer; publish a complete divisor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_NONE;
            hi_next <= 1'b0;
            lo_hold <= '0;
            div_q   <= '0;
            div_new <= 1'b0;
        end else begin
            div_new <= 1'b0;
            if (cfg_load) begin
                acc_q   <= cfg_acc;
                hi_next <= 1'b0;
            end else if (data_we) begin
                case (acc_q)
                    ACC_LO: begin
                        div_q   <= {{BYTE_W{1'b0}}, wdata};
                        div_new <= 1'b1;
                    end
                    ACC_HI: begin
                        div_q   <= {wdata, {BYTE_W{1'b0}}};
                        div_new <= 1'b1;
                    end
                    ACC_BOTH: begin
                        if (!hi_next) begin
                            lo_hold <= wdata;
                            hi_next <= 1'b1;
                        end else begin
                            div_q   <= {wdata, lo_hold};
                            hi_next <= 1'b0;
                            div_new <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr_sq_counter.sv
// Module: tmr_sq_counter
// Half-period down-counter producing the square wave.
// Assumes: the divisor input is stable between publications; it is sampled
// only at start and at each half-period reload.
module tmr_sq_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_stop,
    input  logic             div_new,
    input  logic [DIV_W-1:0] div_in,
    input  logic             tick_en,
    output logic             wave
);
    logic             run_q;
    logic             wave_q;
    logic [DIV_W-1:0] cnt_q;

    // Length of one half-period: high half takes the odd tick, zero means 2^DIV_W
    function automatic logic [DIV_W-1:0] half_len(input logic [DIV_W-1:0] d,
                                                  input logic hi);
        logic [DIV_W:0] full;
        logic [DIV_W:0] h;
        full = (d == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, d};
        h    = hi ? ((full + 1'b1) >> 1) : (full >> 1);
        if (h == '0) h = (DIV_W+1)'(1);
        return h[DIV_W-1:0];
    endfunction

    // Stop on arming, start on first divisor, toggle and reload at half ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            wave_q <= 1'b0;
            cnt_q  <= '0;
        end else if (arm_stop) begin
            run_q  <= 1'b0;
            wave_q <= 1'b1;
            cnt_q  <= '0;
        end else if (div_new && !run_q) begin
            run_q  <= 1'b1;
            wave_q <= 1'b1;
            cnt_q  <= half_len(div_in, 1'b1);
        end else if (run_q && tick_en) begin
            if (cnt_q == DIV_W'(1)) begin
                wave_q <= !wave_q;
                cnt_q  <= half_len(div_in, !wave_q);
            end else begin
                cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign wave = wave_q;
endmodule

// File: rtl/tmr_channel.sv
// Module: tmr_channel (top)
// One square-wave interval timer channel with control and data byte ports.
// Assumes: tick_en is a one-cycle strobe synchronous to clk; one write per cycle.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       ctl_we,
    input  logic       data_we,
    input  logic [7:0] wdata,
    output logic       irq_out
);
    logic             cfg_ok;
    acc_e             cfg_acc;
    logic [DIV_W-1:0] div_q;
    logic             div_new;

    tmr_ctl_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .ctl_we   (ctl_we),
        .wdata    (wdata),
        .accept   (cfg_ok),
        .acc_mode (cfg_acc)
    );

    tmr_load_seq u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_ok),
        .cfg_acc  (cfg_acc),
        .data_we  (data_we),
        .wdata    (wdata),
        .div_q    (div_q),
        .div_new  (div_new)
    );

    tmr_sq_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_stop (cfg_ok),
        .div_new  (div_new),
        .div_in   (div_q),
        .tick_en  (tick_en),
        .wave     (irq_out)
    );
endmodule

// File: rtl/tmr_channel_chk.sv
// Module: tmr_channel_chk
// Port-level properties of the timer channel, bound into tmr_channel.
module tmr_channel_chk #(
    parameter int CHAN_ID = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       ctl_we,
    input logic       data_we,
    input logic [7:0] wdata,
    input logic       irq_out
);
    logic ctl_ok;
    logic ctl_bad;

    // Control-word acceptance as seen from the ports
    always_comb begin
        ctl_ok  = ctl_we && (wdata[7:6] == 2'(CHAN_ID)) && (wdata[5:4] != 2'b00)
                  && (wdata[2:1] == 2'b11) && !wdata[0];
        ctl_bad = ctl_we && !ctl_ok;
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !irq_out);

    // R3
    arm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ok |=> irq_out);

    // R2
    bad_ctl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_bad && !tick_en && !data_we) |=> $stable(irq_out));

    // R9
    edge_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(irq_out)) |-> ($past(tick_en) || $past(ctl_ok)));
endmodule

bind tmr_channel tmr_channel_chk #(.CHAN_ID(CHAN_ID)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .ctl_we  (ctl_we),
    .data_we (data_we),
    .wdata   (wdata),
    .irq_out (irq_out)
);

// File: tb/tmr_channel_tb.sv
// Bench for tmr_channel: table-driven period checks, then directed corner cases.
module tmr_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       ctl_we = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       irq_out;

    int checks = 0;
    int errors = 0;
    int tick_gap = 1;
    int ph = 0;

    tmr_channel u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .ctl_we  (ctl_we),
        .data_we (data_we),
        .wdata   (wdata),
        .irq_out (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick strobe every tick_gap cycles; 0 stops ticks
    always @(negedge clk) begin
        if (tick_gap == 0) begin
            tick_en = 1'b0;
            ph = 0;
        end else if (ph >= tick_gap - 1) begin
            tick_en = 1'b1;
            ph = 0;
        end else begin
            tick_en = 1'b0;
            ph = ph + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  ctl;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [1:0]  nb;
        logic [3:0]  gap;
        logic [19:0] ehi;
        logic [19:0] elo;
        logic [3:0]  rq;
    } vec_t;

    // ctl, byte0, byte1, byte count, tick gap, high cycles, low cycles, requirement
    localparam vec_t VECS [9] = '{
        '{8'h36, 8'h0A, 8'h00, 2'd2, 4'd1, 20'd5,   20'd5,   4'd6},
        '{8'h36, 8'h07, 8'h00, 2'd2, 4'd1, 20'd4,   20'd3,   4'd6},
        '{8'h36, 8'h05, 8'h01, 2'd2, 4'd1, 20'd131, 20'd130, 4'd4},
        '{8'h16, 8'h09, 8'h00, 2'd1, 4'd1, 20'd5,   20'd4,   4'd5},
        '{8'h26, 8'h01, 8'h00, 2'd1, 4'd1, 20'd128, 20'd128, 4'd5},
        '{8'h3E, 8'h06, 8'h00, 2'd2, 4'd1, 20'd3,   20'd3,   4'd2},
        '{8'h36, 8'h06, 8'h00, 2'd2, 4'd3, 20'd9,   20'd9,   4'd9},
        '{8'h36, 8'h01, 8'h00, 2'd2, 4'd1, 20'd1,   20'd1,   4'd10},
        '{8'h36, 8'h02, 8'h00, 2'd2, 4'd2, 20'd2,   20'd2,   4'd9}
    };

    function automatic string tag(input int r);
        case (r)
            2:  return "R2";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            9:  return "R9";
            10: return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_we = 1'b1; wdata = v;
        @(negedge clk); data_we = 1'b0;
    endtask

    // Skip to the next low level, then count low and high cycle lengths
    task automatic measure(output int lo, output int hi);
        lo = 0; hi = 0;
        while (irq_out == 1'b1) @(negedge clk);
        while (irq_out == 1'b0) begin lo++; @(negedge clk); end
        while (irq_out == 1'b1) begin hi++; @(negedge clk); end
    endtask

    task automatic count_changes(input int n, output int ch);
        logic prev;
        ch = 0;
        prev = irq_out;
        repeat (n) begin
            @(negedge clk);
            if (irq_out != prev) ch++;
            prev = irq_out;
        end
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", WDOG_CYC);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lo, hi, ch;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and ticks without programming
        chk("R1 reset level", irq_out, 0);
        count_changes(20, ch);
        chk("R1 idle with ticks", ch, 0);
        wr_data(8'h05);
        wr_data(8'h00);
        count_changes(20, ch);
        chk("R1 data before control word", ch + irq_out, 0);

        // R3: armed but incomplete divisor holds output high
        wr_ctl(8'h36);
        chk("R3 high after control word", irq_out, 1);
        wr_data(8'h04);
        count_changes(30, ch);
        chk("R3 holds with one byte", ch, 0);
        chk("R3 level with one byte", irq_out, 1);
        wr_data(8'h00);
        measure(lo, hi);
        chk("R3 low after completion", lo, 2);
        chk("R3 high after completion", hi, 2);

        // Table walk
        foreach (VECS[i]) begin
            tick_gap = int'(VECS[i].gap);
            wr_ctl(VECS[i].ctl);
            wr_data(VECS[i].b0);
            if (VECS[i].nb == 2'd2) wr_data(VECS[i].b1);
            measure(lo, hi);
            chk({tag(int'(VECS[i].rq)), " table high"}, hi, int'(VECS[i].ehi));
            chk({tag(int'(VECS[i].rq)), " table low"}, lo, int'(VECS[i].elo));
        end

        // R2: rejected control words leave a running wave untouched
        tick_gap = 1;
        wr_ctl(8'h36); wr_data(8'h0A); wr_data(8'h00);
        measure(lo, hi);
        wr_ctl(8'h76);
        wr_ctl(8'h06);
        wr_ctl(8'h34);
        wr_ctl(8'h37);
        measure(lo, hi);
        chk("R2 low after rejected words", lo, 5);
        chk("R2 high after rejected words", hi, 5);

        // R8: new divisor during a low half applies at the next boundary
        while (irq_out == 1'b1) @(negedge clk);
        data_we = 1'b1; wdata = 8'h14;
        @(negedge clk); wdata = 8'h00;
        @(negedge clk); data_we = 1'b0;
        lo = 2;
        while (irq_out == 1'b0) begin lo++; @(negedge clk); end
        hi = 0;
        while (irq_out == 1'b1) begin hi++; @(negedge clk); end
        chk("R8 current half keeps old length", lo, 5);
        chk("R8 next half uses new divisor", hi, 10);
        lo = 0;
        while (irq_out == 1'b0) begin lo++; @(negedge clk); end
        chk("R8 following low half", lo, 10);

        // R9: no ticks, no movement
        tick_gap = 0;
        repeat (2) @(negedge clk);
        count_changes(50, ch);
        chk("R9 stalled without ticks", ch, 0);
        tick_gap = 1;

        // R7: zero divisor means 65536
        wr_ctl(8'h36); wr_data(8'h00); wr_data(8'h00);
        measure(lo, hi);
        chk("R7 low half of 65536", lo, 32768);
        chk("R7 high half of 65536", hi, 32768);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule